// File: doc/BRIEF.md
# Sync-Aligned Serial Byte Receiver

This block sits behind a bit-recovery stage that delivers one received bit at a time, together with a strobe that marks the clock cycle in which that bit is valid. The block keeps the last sixteen received bits and compares them with three programmable 16-bit sync patterns on every strobe. A match on any pattern sets that pattern's own status flag. It also restarts the byte counter and clears a running CRC-16. From then on, every eighth bit completes a byte. That byte lands in a data register and raises a byte-ready flag.

The CRC covers every bit since the last sync. A frame that carries its own two-byte CRC at the end leaves a zero residue, so at that byte boundary a checksum-good flag is raised next to byte-ready. Software has to know the frame length: checksum-good only means something at the boundary of the second CRC byte. Byte-ready keeps firing every eight bits whether or not a frame is in progress.

Software reaches the block through a small synchronous register port with an address, a write enable and a read strobe. Reading the status word clears all its flags. An active-low interrupt stays low while any flag is set.

Top module: `sync_byte_rx`

## Requirements
- R1: Three pattern registers sit at addresses 2, 3 and 4, with reset values 16'hB433, 16'h2B6D and 16'h7E81. On each strobe, the history (new bit shifted in at bit 0, so the first-sent bit of a pattern ends at bit 15) is compared with each pattern. A match sets status bit 0, 1 or 2 respectively.
- R2: A strobe that matches any pattern leaves the CRC register at zero.
- R3: A strobe that matches any pattern restarts byte counting, so the next byte completes on the eighth following strobe. If that strobe would also have completed a byte, no byte is produced.
- R4: Every eighth strobe since reset or since the last match (not counting the matching strobe itself) completes a byte, frame or not. The byte is loaded into the data register (address 1, bits 7:0, first-received bit in bit 7) and status bit 3 (byte-ready) is set.
- R5: The CRC is CRC-16 with polynomial 16'h1021, initial value zero, fed MSB first with every non-matching strobed bit. If the CRC including a byte's last bit is zero, status bit 4 is set together with bit 3. After a frame ending with its CRC (high byte first), bit 4 is set and the data register holds the CRC low byte.
- R6: A read strobe at address 0 returns status bits 4:0 on the read data port in the next cycle (upper bits zero) and clears every flag.
- R7: The interrupt output is low exactly while at least one status flag is set, changing in the same cycle as the flags.
- R8: If a status read and a flag-setting event fall in the same clock, the flag stays set after the read. The read itself returns the value from before the event.
- R9: A read strobe at any address updates the read data port in the next cycle and holds it otherwise. Pattern registers read back what was written. Writes to addresses 0 and 1 have no effect. Addresses 5 to 7 read as zero.
- R10: While the strobe is low, the received bit is ignored: history, byte counter, CRC and flags do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a valid received bit |
| bit_in | input | 1 | Received bit |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status read can land in the same clock as a byte completion or a sync match. In that case the clear-on-read and the new flag both act on the same register. The bench provokes this in a directed test by issuing the status read on exactly the eighth bit after a sync. Random traffic reads the status word at arbitrary moments while bits stream in, so the same collision also happens there. The result is judged by comparing the returned value with a bench model, which must show the pre-event flags. A second read must then show the byte-ready flag still set, and the interrupt must stay low in between.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_DATA   = 1;
  localparam int PAT_BASE    = 2;

  // status layout: sync flags in [N_SYNC-1:0], byte-ready next, checksum-good above it
  function automatic int flag_byte(input int n_sync);
    return n_sync;
  endfunction

  function automatic int flag_crc(input int n_sync);
    return n_sync + 1;
  endfunction
endpackage

// File: rtl/sbr_sync_bank.sv
module sbr_sync_bank #(
  parameter int SYNC_W = 16,
  parameter int N_SYNC = 3,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter logic [N_SYNC*SYNC_W-1:0] PAT_INIT = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_valid,
  input  logic                     bit_in,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [N_SYNC-1:0]        sync_hit,
  output logic [N_SYNC*SYNC_W-1:0] pat_flat
);
  import sbr_pkg::*;

  logic [SYNC_W-1:0] hist_q;
  logic [SYNC_W-1:0] hist_n;

  assign hist_n = {hist_q[SYNC_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (bit_valid) begin
      hist_q <= hist_n;
    end
  end

  for (genvar g = 0; g < N_SYNC; g++) begin : g_pat
    logic [SYNC_W-1:0] pat_q;
    logic              sel;

    assign sel = reg_wr && (reg_addr == ADDR_W'(PAT_BASE + g));

    always_ff @(posedge clk) begin
      if (rst) begin
        pat_q <= PAT_INIT[g*SYNC_W +: SYNC_W];
      end else if (sel) begin
        pat_q <= reg_wdata[SYNC_W-1:0];
      end
    end

    assign sync_hit[g] = bit_valid && (hist_n == pat_q);
    assign pat_flat[g*SYNC_W +: SYNC_W] = pat_q;
  end
endmodule

// File: rtl/sbr_framer.sv
module sbr_framer #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             sync_any,
  output logic             byte_evt,
  output logic [BYTE_W-1:0] data_q,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [BYTE_W-2:0] sh_q;
  logic              last_bit;

  assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));
  assign byte_evt = bit_valid && !sync_any && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sh_q    <= '0;
      data_q  <= '0;
    end else if (bit_valid) begin
      sh_q <= {sh_q[BYTE_W-3:0], bit_in};
      if (sync_any) begin
        bit_cnt <= '0;
      end else if (last_bit) begin
        bit_cnt <= '0;
        data_q  <= {sh_q, bit_in};
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbr_crc.sv
module sbr_crc #(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             sync_any,
  output logic [CRC_W-1:0] crc_q,
  output logic             zero_next
);
  logic             fb;
  logic [CRC_W-1:0] crc_n;

  assign fb        = crc_q[CRC_W-1] ^ bit_in;
  assign crc_n     = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  assign zero_next = (crc_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else if (bit_valid) begin
      crc_q <= sync_any ? '0 : crc_n;
    end
  end
endmodule

// File: rtl/sbr_status.sv
module sbr_status #(
  parameter int N_FLAGS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [N_FLAGS-1:0] flag_set,
  output logic [N_FLAGS-1:0] status_q,
  output logic               irq_n
);
  logic [N_FLAGS-1:0] status_n;

  // a set in the clearing clock survives
  assign status_n = (clr ? '0 : status_q) | flag_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_n    <= 1'b1;
    end else begin
      status_q <= status_n;
      irq_n    <= ~|status_n;
    end
  end
endmodule

// File: rtl/sync_byte_rx.sv
module sync_byte_rx #(
  parameter int SYNC_W = 16,
  parameter int N_SYNC = 3,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter logic [SYNC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [N_SYNC*SYNC_W-1:0] PAT_INIT = {16'h7E81, 16'h2B6D, 16'hB433}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  import sbr_pkg::*;

  localparam int N_FLAGS = N_SYNC + 2;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int F_BYTE  = flag_byte(N_SYNC);
  localparam int F_CRC   = flag_crc(N_SYNC);

  logic [N_SYNC-1:0]        sync_hit;
  logic                     sync_any;
  logic [N_SYNC*SYNC_W-1:0] pat_flat;
  logic                     byte_evt;
  logic [BYTE_W-1:0]        data_q;
  logic [CNT_W-1:0]         bit_cnt;
  logic [SYNC_W-1:0]        crc_q;
  logic                     crc_zero;
  logic [N_FLAGS-1:0]       flag_set;
  logic [N_FLAGS-1:0]       status_q;
  logic                     status_clr;
  logic [DATA_W-1:0]        rd_mux;

  assign sync_any = |sync_hit;

  sbr_sync_bank #(
    .SYNC_W(SYNC_W), .N_SYNC(N_SYNC), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .PAT_INIT(PAT_INIT)
  ) u_sync (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .sync_hit(sync_hit), .pat_flat(pat_flat)
  );

  sbr_framer #(.BYTE_W(BYTE_W)) u_framer (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_any(sync_any), .byte_evt(byte_evt), .data_q(data_q),
    .bit_cnt(bit_cnt)
  );

  sbr_crc #(.CRC_W(SYNC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_any(sync_any), .crc_q(crc_q), .zero_next(crc_zero)
  );

  always_comb begin
    flag_set = '0;
    flag_set[N_SYNC-1:0] = sync_hit;
    flag_set[F_BYTE]     = byte_evt;
    flag_set[F_CRC]      = byte_evt && crc_zero;
  end

  assign status_clr = reg_rd && (reg_addr == ADDR_W'(ADDR_STATUS));

  sbr_status #(.N_FLAGS(N_FLAGS)) u_status (
    .clk(clk), .rst(rst), .clr(status_clr), .flag_set(flag_set),
    .status_q(status_q), .irq_n(irq_n)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADDR_STATUS)) begin
      rd_mux = DATA_W'(status_q);
    end else if (reg_addr == ADDR_W'(ADDR_DATA)) begin
      rd_mux = DATA_W'(data_q);
    end
    for (int i = 0; i < N_SYNC; i++) begin
      if (reg_addr == ADDR_W'(PAT_BASE + i)) begin
        rd_mux = DATA_W'(pat_flat[i*SYNC_W +: SYNC_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int N_FLAGS = 5,
  parameter int CNT_W   = 3,
  parameter int CRC_W   = 16,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               bit_valid,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               sync_any,
  input logic               byte_evt,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [CRC_W-1:0]   crc_q,
  input logic [N_FLAGS-1:0] flag_set,
  input logic [N_FLAGS-1:0] status_q,
  input logic               irq_n
);
  p_sync_clears_crc_r2: assert property (@(posedge clk) disable iff (rst)
    sync_any |=> (crc_q == '0));

  p_sync_restarts_count_r3: assert property (@(posedge clk) disable iff (rst)
    sync_any |=> (bit_cnt == '0));

  p_no_byte_on_sync_r3: assert property (@(posedge clk) disable iff (rst)
    sync_any |-> !byte_evt);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == '0 && flag_set == '0) |=> (status_q == '0));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (|flag_set) |=> ((status_q & $past(flag_set)) == $past(flag_set)));

  p_irq_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|status_q));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(bit_cnt) && $stable(crc_q)));
endmodule

bind sync_byte_rx sbr_checker #(
  .N_FLAGS(N_FLAGS), .CNT_W(CNT_W), .CRC_W(SYNC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .sync_any(sync_any), .byte_evt(byte_evt),
  .bit_cnt(bit_cnt), .crc_q(crc_q), .flag_set(flag_set),
  .status_q(status_q), .irq_n(irq_n)
);

// File: tb/test_sync_byte_rx.sv
module test_sync_byte_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bit_valid, bit_in, reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_hist, m_crc;
  logic [15:0] m_pat [3];
  logic [7:0]  m_data;
  logic [4:0]  m_flags;
  int          m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_byte_rx i_sync_byte_rx (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic [15:0] s;
    s = {c[14:0], 1'b0};
    if (c[15] ^ b) s = s ^ 16'h1021;
    return s;
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) r = crc_bit(r, d[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {11'd0, m_flags};
      3'd1: return {8'd0, m_data};
      3'd2, 3'd3, 3'd4: return m_pat[a - 3'd2];
      default: return 16'd0;
    endcase
  endfunction

  // one clock: drive at negedge, update model, check after the edge
  task automatic step(input logic v, input logic b, input logic rd,
                      input logic [2:0] a, input logic wr, input logic [15:0] wd,
                      input string req);
    logic [15:0] rexp, hn;
    logic [4:0]  set;
    bit          hit;
    bit_valid = v; bit_in = b; reg_rd = rd; reg_addr = a; reg_wr = wr; reg_wdata = wd;
    rexp = model_read(a);
    set = '0;
    if (v) begin
      hn = {m_hist[14:0], b};
      hit = 1'b0;
      for (int i = 0; i < 3; i++) if (hn == m_pat[i]) begin set[i] = 1'b1; hit = 1'b1; end
      if (hit) begin
        m_cnt = 0; m_crc = '0;
      end else begin
        m_crc = crc_bit(m_crc, b);
        if (m_cnt == 7) begin
          m_cnt = 0; m_data = hn[7:0]; set[3] = 1'b1;
          if (m_crc == 16'd0) set[4] = 1'b1;
        end else m_cnt++;
      end
      m_hist = hn;
    end
    m_flags = ((rd && a == 3'd0) ? 5'd0 : m_flags) | set;
    if (wr && a >= 3'd2 && a <= 3'd4) m_pat[a - 3'd2] = wd;
    @(posedge clk);
    @(negedge clk);
    if (rd) check(req, reg_rdata, rexp);
    check("R7", {15'd0, irq_n}, {15'd0, ~|m_flags});
  endtask

  task automatic idle_read(input logic [2:0] a, input string req);
    step(1'b0, 1'b0, 1'b1, a, 1'b0, 16'd0, req);
  endtask

  task automatic send_bit(input logic b);
    step(1'b1, b, 1'b0, 3'd0, 1'b0, 16'd0, "");
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  pay [4];
    logic [15:0] c;
    void'($urandom(32'd5150));
    bit_valid = 0; bit_in = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rst = 1'b1;
    m_hist = '0; m_crc = '0; m_data = '0; m_flags = '0; m_cnt = 0;
    m_pat[0] = 16'hB433; m_pat[1] = 16'h2B6D; m_pat[2] = 16'h7E81;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R7 reset irq", {15'd0, irq_n}, 16'd1);
    idle_read(3'd0, "R6 reset status");
    check("R6 reset status literal", reg_rdata, 16'd0);
    idle_read(3'd2, "R1 default pattern 0");
    check("R1 default pattern 0 literal", reg_rdata, 16'hB433);
    idle_read(3'd3, "R1 default pattern 1");
    idle_read(3'd4, "R1 default pattern 2");
    idle_read(3'd6, "R9 unused address");

    // byte ready with no frame
    send_byte(8'hA5);
    idle_read(3'd0, "R4 byte ready w/o frame");
    check("R4 byte flag literal", reg_rdata & 16'h0008, 16'h0008);
    idle_read(3'd1, "R4 data register");
    check("R4 data literal", reg_rdata, 16'h00A5);

    // writes to status/data ignored
    step(1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 16'h5555, "");
    step(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 16'h001F, "");
    idle_read(3'd1, "R9 data write ignored");
    idle_read(3'd0, "R9 status write ignored");

    // good frame on pattern 0
    send_word(16'hB433);
    idle_read(3'd0, "R1 sync 0 flag");
    check("R1 sync 0 literal", reg_rdata & 16'h0001, 16'h0001);
    pay[0] = 8'h12; pay[1] = 8'hF0; pay[2] = 8'h3C; pay[3] = 8'h81;
    c = 16'd0;
    for (int i = 0; i < 4; i++) begin c = crc_byte(c, pay[i]); send_byte(pay[i]); end
    send_byte(c[15:8]);
    send_byte(c[7:0]);
    idle_read(3'd0, "R5 frame status");
    check("R5 crc good literal", reg_rdata & 16'h0018, 16'h0018);
    idle_read(3'd1, "R5 last crc byte in data");
    check("R5 data literal", reg_rdata, {8'd0, c[7:0]});

    // corrupted frame on pattern 2
    send_word(16'h7E81);
    idle_read(3'd0, "R1 sync 2 flag");
    for (int i = 0; i < 4; i++) send_byte(pay[i] ^ ((i == 1) ? 8'h04 : 8'h00));
    send_byte(c[15:8]);
    send_byte(c[7:0]);
    idle_read(3'd0, "R5 bad frame status");
    check("R5 no crc good literal", reg_rdata & 16'h0010, 16'h0000);

    // R3: sync on a would-be byte boundary
    send_word(16'hB433);
    idle_read(3'd0, "R3 clear");
    for (int i = 15; i >= 1; i--) send_bit(1'((16'h2B6D >> i) & 16'h1));
    idle_read(3'd0, "R3 mid");
    send_bit(1'b1);
    idle_read(3'd0, "R3 sync at boundary");
    check("R3 only sync 1 literal", reg_rdata, 16'h0002);

    // R2/R3: after sync, 8 bits make a byte; crc of a zero byte from reset crc is zero
    send_byte(8'h00);
    idle_read(3'd0, "R2 crc cleared by sync");
    check("R2 zero byte crc good literal", reg_rdata & 16'h0018, 16'h0018);

    // R8: status read in same clock as byte completion
    send_word(16'h2B6D);
    idle_read(3'd0, "R8 clear");
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    step(1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 16'd0, "R8 read at event");
    check("R8 irq still low", {15'd0, irq_n}, 16'd0);
    idle_read(3'd0, "R8 flag kept");
    check("R8 byte flag literal", reg_rdata & 16'h0008, 16'h0008);

    // R10: strobe low, bit ignored
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    idle_read(3'd0, "R10 clear");
    for (int i = 0; i < 40; i++) step(1'b0, 1'($urandom_range(1)), 1'b0, 3'd0, 1'b0, 16'd0, "");
    idle_read(3'd0, "R10 no flags while idle");
    check("R10 no flag literal", reg_rdata, 16'd0);
    send_byte(8'h6B);
    idle_read(3'd1, "R10 count resumed");

    // pattern write/readback
    step(1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 16'hC0DE, "");
    idle_read(3'd3, "R9 pattern readback");
    check("R9 pattern literal", reg_rdata, 16'hC0DE);
    send_word(16'hC0DE);
    idle_read(3'd0, "R1 new pattern matches");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [2:0] a;
      r = $urandom_range(99);
      a = 3'($urandom_range(7));
      if (r < 3) begin
        send_word(m_pat[$urandom_range(2)]);
      end else if (r < 5) begin
        step(1'b0, 1'b0, 1'b0, a, 1'b1, 16'($urandom), "");
      end else begin
        logic rd;
        string lbl;
        rd = ($urandom_range(9) == 0);
        lbl = (a == 3'd0) ? "R6 random status" : (a == 3'd1) ? "R4 random data" : "R9 random read";
        step(1'($urandom_range(1)), 1'($urandom_range(1)), rd, a, 1'b0, 16'd0, lbl);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule